// File: doc/BRIEF.md
# Serial DAC Control Port Decoder

This block is the digital front end of a pair of serial-loaded 8-bit DACs and of the offset-trim controls for two parallel DAC channels. A host shifts 10-bit words into one shared port on a gated serial clock that idles low, data first from the most significant bit. The top two bits of each word pick one of four targets: the holding latch of DAC 0, the holding latch of DAC 1, or the offset-trim register of parallel channel A or channel B. A separate latch strobe moves both DAC holding latches into the DAC output registers at the same time. Those output registers drive the converters.

All inputs are brought into the system clock domain through two-flop synchronizers, and edge detection happens there. The system clock must run at least four times faster than the serial clock. A small frame controller counts serial clock edges since the port was last idle. It accepts a word only when exactly ten edges have arrived at the moment the strobe rises, or at the moment an idle timeout of `IDLE_CYC` system cycles expires. Any other non-zero count drops the word and raises a one-cycle framing-error pulse.

The frame controller has three states. `FR_IDLE` waits for the first serial clock edge, which moves it to `FR_RECV`. `FR_RECV` shifts and counts bits. A strobe rising edge or the idle timeout moves it to `FR_JUDGE`. `FR_JUDGE` lasts one cycle: it either commits the word or flags the framing error, then returns to `FR_IDLE`. A strobe that rises while the controller is in `FR_IDLE` causes no transition. A low level on the power-down input forces both DAC outputs to zero. Words are still accepted into the holding latches during that time.

Top module: `serdac_port`

## Requirements
- R1: After reset both DAC codes, all trim fields and `frame_err` are zero.
- R2: A word is taken MSB first, one bit per serial clock rising edge. Word bits [9:8] equal to 2'b10 write bits [7:0] into the DAC 0 holding latch, and 2'b01 writes them into the DAC 1 holding latch. A DAC output does not change when its holding latch is written.
- R3: A falling edge of the latch strobe copies both holding latches into `dac0_code` and `dac1_code` in the same cycle. Apart from that, the DAC outputs keep their value.
- R4: Word bits [9:8] equal to 2'b00 write channel A trim: bit 5 goes to `trim_a_user` (1 selects the user value), bit 4 goes to `trim_a_raise` (1 raises the output, 0 lowers it), and bits [3:0] go to `trim_a_mag`. Bits [7:6] are ignored. Channel B is left unchanged.
- R5: Word bits [9:8] equal to 2'b11 write channel B trim with the same field positions as R4. Channel A is left unchanged.
- R6: A word is committed when exactly 10 serial clock edges have been counted at the strobe's rising edge, or when `IDLE_CYC` system cycles pass with no serial clock edge. A strobe word is committed before the transfer on that strobe's falling edge.
- R7: A non-zero edge count other than 10 at the strobe's rising edge or at the timeout discards the word, leaves every register unchanged, and gives a single-cycle `frame_err` pulse.
- R8: While `sdac_run` is low, both DAC codes are 0. Writes into the holding latches continue. After `sdac_run` returns high, the codes stay 0 until the next strobe falling edge, which then shows the held values.
- R9: DAC codes are straight binary and pass through bit-exact: 8'h00 and 8'hFF reach the outputs unchanged.
- R10: A strobe with no serial bits since the last commit raises no framing error and still transfers the holding latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_din | input | 1 | Serial data |
| ser_clk | input | 1 | Gated serial clock, idles low |
| load_strobe | input | 1 | Latch strobe, idles low |
| sdac_run | input | 1 | Low powers down the serial DACs |
| dac0_code | output | 8 | DAC 0 output code |
| dac1_code | output | 8 | DAC 1 output code |
| trim_a_user | output | 1 | Channel A: 1 selects the user trim |
| trim_a_raise | output | 1 | Channel A: trim direction, 1 raises |
| trim_a_mag | output | 4 | Channel A trim magnitude |
| trim_b_user | output | 1 | Channel B: 1 selects the user trim |
| trim_b_raise | output | 1 | Channel B: trim direction, 1 raises |
| trim_b_mag | output | 4 | Channel B trim magnitude |
| frame_err | output | 1 | One-cycle framing-error pulse |

## Verification
The assertions assume that the serial clock and the strobe stay at each level for at least two system cycles. They also assume that no serial clock edge arrives within the one cycle of `FR_JUDGE`, and that serial data is stable around each serial clock rising edge. The stimulus holds every serial clock phase for four system cycles and changes data only while the serial clock is low. It raises the strobe only after the serial clock has returned low, and it keeps the strobe high for six cycles. Timeout commits are reached by leaving the port quiet for well over `IDLE_CYC` cycles.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
    parameter int WORD_W = 10;
    parameter int CODE_W = 8;
    parameter int TRIM_W = 4;
    parameter int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        TGT_TRIM_A = 2'b00,
        TGT_DAC1   = 2'b01,
        TGT_DAC0   = 2'b10,
        TGT_TRIM_B = 2'b11
    } tgt_e;

    typedef struct packed {
        logic              user_sel;
        logic              raise;
        logic [TRIM_W-1:0] mag;
    } trim_t;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_RECV  = 2'd1,
        FR_JUDGE = 2'd2
    } fr_state_e;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [STAGES:0] pipe;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= '0;
                end else begin
                    pipe <= {pipe[STAGES-1:0], din[g]};
                end
            end
            assign lvl[g]  = pipe[STAGES-1];
            assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
            assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
        end
    endgenerate
endmodule

// File: rtl/serdac_frame.sv
module serdac_frame
    import serdac_pkg::*;
#(
    parameter int IDLE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              sck_rise,
    input  logic              stb_rise,
    output logic [WORD_W-1:0] word,
    output logic              commit,
    output logic              bad_frame
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam int TMR_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(IDLE_CYC - 1);

    fr_state_e         state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [TMR_W-1:0]  idle_tmr;
    logic [WORD_W-1:0] shreg;
    logic              timeout;

    assign timeout = (idle_tmr == TMR_END);
    assign word    = shreg;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:  if (sck_rise) state_nx = FR_RECV;
            FR_RECV:  if (stb_rise || (timeout && !sck_rise)) state_nx = FR_JUDGE;
            FR_JUDGE: state_nx = FR_IDLE;
            default:  state_nx = FR_IDLE;
        endcase
    end

    // outputs of the frame controller
    always_comb begin
        commit    = 1'b0;
        bad_frame = 1'b0;
        unique case (state)
            FR_JUDGE: begin
                commit    = (bit_cnt == CNT_FULL);
                bad_frame = (bit_cnt != CNT_FULL);
            end
            default: begin
                commit    = 1'b0;
                bad_frame = 1'b0;
            end
        endcase
    end

    // shift register and saturating edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state == FR_JUDGE) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[WORD_W-2:0], bit_in};
            if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // idle timer, running only while receiving
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_tmr <= '0;
        end else if (state != FR_RECV || sck_rise) begin
            idle_tmr <= '0;
        end else if (!timeout) begin
            idle_tmr <= idle_tmr + 1'b1;
        end
    end
endmodule

// File: rtl/serdac_regs.sv
module serdac_regs
    import serdac_pkg::*;
#(
    parameter int NUM_DAC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              commit,
    input  logic              xfer,
    input  logic              pwr_on,
    output logic [CODE_W-1:0] code [NUM_DAC],
    output trim_t             trim_a,
    output trim_t             trim_b
);
    tgt_e tgt;
    assign tgt = tgt_e'(word[WORD_W-1 -: ADDR_W]);

    logic [CODE_W-1:0] hold [NUM_DAC];
    trim_t             trim_word;

    assign trim_word = '{user_sel: word[TRIM_W+1],
                         raise:    word[TRIM_W],
                         mag:      word[TRIM_W-1:0]};

    generate
        for (genvar d = 0; d < NUM_DAC; d++) begin : g_dac
            // DAC d is addressed by TGT_DAC0 for d=0, TGT_DAC1 for d=1
            localparam tgt_e MY_TGT = (d == 0) ? TGT_DAC0 : TGT_DAC1;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold[d] <= '0;
                end else if (commit && tgt == MY_TGT) begin
                    hold[d] <= word[CODE_W-1:0];
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    code[d] <= '0;
                end else if (!pwr_on) begin
                    code[d] <= '0;
                end else if (xfer) begin
                    code[d] <= hold[d];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_a <= '0;
            trim_b <= '0;
        end else if (commit) begin
            if (tgt == TGT_TRIM_A) trim_a <= trim_word;
            if (tgt == TGT_TRIM_B) trim_b <= trim_word;
        end
    end
endmodule

// File: rtl/serdac_port.sv
module serdac_port
    import serdac_pkg::*;
#(
    parameter int IDLE_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_din,
    input  logic              ser_clk,
    input  logic              load_strobe,
    input  logic              sdac_run,
    output logic [CODE_W-1:0] dac0_code,
    output logic [CODE_W-1:0] dac1_code,
    output logic              trim_a_user,
    output logic              trim_a_raise,
    output logic [TRIM_W-1:0] trim_a_mag,
    output logic              trim_b_user,
    output logic              trim_b_raise,
    output logic [TRIM_W-1:0] trim_b_mag,
    output logic              frame_err
);
    localparam int LN_DIN = 0;
    localparam int LN_SCK = 1;
    localparam int LN_STB = 2;
    localparam int LN_PWR = 3;
    localparam int LANES  = 4;
    localparam int NUM_DAC = 2;

    logic [LANES-1:0]  s_lvl, s_rise, s_fall;
    logic [WORD_W-1:0] word_w;
    logic              commit_w, xfer_w, pwr_w;
    logic [CODE_W-1:0] code_w [NUM_DAC];
    trim_t             trim_a_w, trim_b_w;

    serdac_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdac_run, load_strobe, ser_clk, ser_din}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign xfer_w = s_fall[LN_STB];
    assign pwr_w  = s_lvl[LN_PWR];

    serdac_frame #(.IDLE_CYC(IDLE_CYC)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (s_lvl[LN_DIN]),
        .sck_rise (s_rise[LN_SCK]),
        .stb_rise (s_rise[LN_STB]),
        .word     (word_w),
        .commit   (commit_w),
        .bad_frame(frame_err)
    );

    serdac_regs #(.NUM_DAC(NUM_DAC)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .word  (word_w),
        .commit(commit_w),
        .xfer  (xfer_w),
        .pwr_on(pwr_w),
        .code  (code_w),
        .trim_a(trim_a_w),
        .trim_b(trim_b_w)
    );

    assign dac0_code    = code_w[0];
    assign dac1_code    = code_w[1];
    assign trim_a_user  = trim_a_w.user_sel;
    assign trim_a_raise = trim_a_w.raise;
    assign trim_a_mag   = trim_a_w.mag;
    assign trim_b_user  = trim_b_w.user_sel;
    assign trim_b_raise = trim_b_w.raise;
    assign trim_b_mag   = trim_b_w.mag;
endmodule

// File: rtl/serdac_chk.sv
module serdac_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_err,
    input logic       commit,
    input logic       xfer,
    input logic       pwr_on,
    input logic [7:0] dac0,
    input logic [7:0] dac1,
    input logic [5:0] trim_a,
    input logic [5:0] trim_b
);
    // R7: framing error is a single-cycle pulse
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R6: a frame is either committed or rejected, never both
    p_commit_xor_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && frame_err));

    // R8: powered-down DACs read zero
    p_pd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (dac0 == 8'h00 && dac1 == 8'h00));

    // R3: outputs only move on a strobe transfer or power-down
    p_hold_dac0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !xfer) |=> $stable(dac0));
    p_hold_dac1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !xfer) |=> $stable(dac1));

    // R4, R5: trim registers only move on a commit
    p_trim_a_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(trim_a));
    p_trim_b_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(trim_b));
endmodule

bind serdac_port serdac_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_err(frame_err),
    .commit   (commit_w),
    .xfer     (xfer_w),
    .pwr_on   (pwr_w),
    .dac0     (dac0_code),
    .dac1     (dac1_code),
    .trim_a   ({trim_a_user, trim_a_raise, trim_a_mag}),
    .trim_b   ({trim_b_user, trim_b_raise, trim_b_mag})
);

// File: tb/tb_serdac_port.sv
module tb_serdac_port;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE_CYC   = 64;

    logic       clk = 0, rst_n = 0;
    logic       ser_din = 0, ser_clk = 0, load_strobe = 0, sdac_run = 1;
    logic [7:0] dac0_code, dac1_code;
    logic       trim_a_user, trim_a_raise, trim_b_user, trim_b_raise, frame_err;
    logic [3:0] trim_a_mag, trim_b_mag;

    int checks = 0, failures = 0, err_seen = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serdac_port #(.IDLE_CYC(IDLE_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
        .load_strobe(load_strobe), .sdac_run(sdac_run),
        .dac0_code(dac0_code), .dac1_code(dac1_code),
        .trim_a_user(trim_a_user), .trim_a_raise(trim_a_raise), .trim_a_mag(trim_a_mag),
        .trim_b_user(trim_b_user), .trim_b_raise(trim_b_raise), .trim_b_mag(trim_b_mag),
        .frame_err(frame_err)
    );

    always @(negedge clk) if (rst_n && frame_err) err_seen++;

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = v[i];
            wait_cyc(2);
            ser_clk = 1;
            wait_cyc(4);
            ser_clk = 0;
            wait_cyc(2);
        end
        ser_din = 0;
    endtask

    task automatic strobe();
        wait_cyc(2);
        load_strobe = 1;
        wait_cyc(6);
        load_strobe = 0;
        wait_cyc(8);
    endtask

    task automatic idle_commit();
        wait_cyc(IDLE_CYC + 20);
    endtask

    task automatic t_reset();
        chk("R1", "dac0", dac0_code, 0);
        chk("R1", "dac1", dac1_code, 0);
        chk("R1", "trim_a", {trim_a_user, trim_a_raise, trim_a_mag}, 0);
        chk("R1", "trim_b", {trim_b_user, trim_b_raise, trim_b_mag}, 0);
        chk("R1", "frame_err", frame_err, 0);
    endtask

    task automatic t_dac0_strobe();
        send_bits({6'd0, 2'b10, 8'hA5}, 10);
        strobe();
        chk("R2", "dac0 after strobe commit", dac0_code, 8'hA5);
        chk("R3", "dac1 unchanged", dac1_code, 0);
        chk("R6", "no error on 10 bits", err_seen, 0);
    endtask

    task automatic t_dac1_timeout();
        send_bits({6'd0, 2'b01, 8'h3C}, 10);
        idle_commit();
        chk("R2", "dac1 output waits for strobe", dac1_code, 0);
        chk("R3", "dac0 holds", dac0_code, 8'hA5);
        strobe();
        chk("R10", "empty strobe transfers dac1", dac1_code, 8'h3C);
        chk("R10", "empty strobe no error", err_seen, 0);
        chk("R6", "timeout commit dac0 kept", dac0_code, 8'hA5);
    endtask

    task automatic t_trim();
        send_bits({6'd0, 2'b00, 2'b11, 1'b1, 1'b0, 4'h9}, 10);
        idle_commit();
        chk("R4", "trim_a", {trim_a_user, trim_a_raise, trim_a_mag}, 6'b10_1001);
        chk("R4", "trim_b untouched", {trim_b_user, trim_b_raise, trim_b_mag}, 0);
        send_bits({6'd0, 2'b11, 2'b10, 1'b1, 1'b1, 4'h6}, 10);
        idle_commit();
        chk("R5", "trim_b", {trim_b_user, trim_b_raise, trim_b_mag}, 6'b11_0110);
        chk("R5", "trim_a untouched", {trim_a_user, trim_a_raise, trim_a_mag}, 6'b10_1001);
        send_bits({6'd0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF}, 10);
        idle_commit();
        chk("R4", "trim_a factory", {trim_a_user, trim_a_raise, trim_a_mag}, 6'b01_1111);
        chk("R3", "dac codes unaffected by trim", {dac0_code, dac1_code}, 16'hA53C);
    endtask

    task automatic t_extremes();
        send_bits({6'd0, 2'b10, 8'h00}, 10);
        idle_commit();
        send_bits({6'd0, 2'b01, 8'hFF}, 10);
        strobe();
        chk("R9", "dac0 zero code", dac0_code, 8'h00);
        chk("R9", "dac1 full code", dac1_code, 8'hFF);
    endtask

    task automatic t_framing();
        send_bits({5'd0, 2'b10, 8'h11, 1'b0}, 11);
        strobe();
        chk("R7", "11 bits flagged", err_seen, 1);
        chk("R7", "11 bits discarded", dac0_code, 8'h00);
        send_bits({6'd0, 2'b01, 8'h22} >> 1, 9);
        idle_commit();
        chk("R7", "9 bits flagged", err_seen, 2);
        strobe();
        chk("R7", "9 bits discarded", dac1_code, 8'hFF);
        chk("R7", "trims kept", {trim_a_mag, trim_b_mag}, 8'hF6);
    endtask

    task automatic t_power();
        sdac_run = 0;
        wait_cyc(6);
        chk("R8", "dac0 forced zero", dac0_code, 0);
        chk("R8", "dac1 forced zero", dac1_code, 0);
        send_bits({6'd0, 2'b10, 8'h77}, 10);
        strobe();
        chk("R8", "strobe while down", dac0_code, 0);
        sdac_run = 1;
        wait_cyc(10);
        chk("R8", "zero after restore", dac0_code, 0);
        strobe();
        chk("R8", "dac0 after restore strobe", dac0_code, 8'h77);
        chk("R8", "dac1 after restore strobe", dac1_code, 8'hFF);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(3);
        t_reset();
        t_dac0_strobe();
        t_dac1_timeout();
        t_trim();
        t_extremes();
        t_framing();
        t_power();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule